// File: doc/BRIEF.md
# Pipelined Global Energy Sum with Threshold Trigger

This block forms one global energy figure from a large set of small cluster energies on every beam crossing. Each cluster value arrives as a 7-bit unsigned number on its own lane. Up to 512 lanes fit the tree; lanes beyond the configured count are tied to zero. The adder tree is built from three levels of eight-way groups. Each eight-way group is made of three registered pairwise adders, and each adder is one bit wider than its operands. The final total is therefore exactly 16 bits wide and cannot wrap. A new input vector may be presented on every clock, and a valid flag travels alongside the data through every stage.

A per-lane enable mask removes a noisy lane from the sum without touching its neighbours. The registered total is then compared against three programmable thresholds to raise three trigger bits. The mask and the thresholds are loaded through a small write port. A write is captured on a clock edge and applies to data that enter the affected stage after that edge.

Top module: `global_sum_trigger`

## Requirements
- R1: With every lane enabled, `out_total` equals the unsigned sum of the 7-bit lane values of the accepted vector. Lane i occupies `in_data[7*i+6:7*i]`.
- R2: A vector may be accepted on every clock with `in_valid` high. Back-to-back vectors each produce their own result, in order, on consecutive cycles.
- R3: The total is 16 bits and never wraps. With 160 lanes all at 127 it reads 20320.
- R4: Mask word w is written at address 4+w. Its bit j enables lane 16*w+j (1 = included, 0 = excluded). An excluded lane contributes zero and leaves the other lanes unaffected. After reset every lane is enabled.
- R5: `out_valid` is high exactly 10 clocks after the edge that accepted a vector with `in_valid` high, and low otherwise. While `out_valid` is low, `out_total` and `out_trig` hold their last values.
- R6: `out_trig[k]` is 1 when the total is greater than or equal to threshold k, and 0 otherwise. Threshold k sits at address k for k = 0..2. After reset every threshold is 0xFFFF.
- R7: A mask write captured on the same edge as an input vector does not affect that vector. It affects vectors accepted on later edges.
- R8: A threshold write is used by every result registered at the output on a later edge.
- R9: During and right after reset, `out_valid`, `out_total` and `out_trig` are all zero.
- R10: A write to address 3, or to any address above the last mask word (13 for 160 lanes), changes neither a threshold nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector present this crossing |
| in_data | input | N_IN*IN_W (1120) | Packed lane energies, lane 0 in the low bits |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W (5) | Configuration address |
| wr_data | input | DATA_W (16) | Configuration data |
| out_valid | output | 1 | Result valid |
| out_total | output | SUM_W (16) | Global sum of the enabled lanes |
| out_trig | output | N_THR (3) | Threshold hit bits |

## Verification
The bench builds the block with its default parameters: 160 lanes, 7-bit values and three eight-way levels. With these values the all-maximum vector reaches the 20320 peak, and the last lane, 159, sits in the upper half of the last mask word. Ten mask words make addresses 14 and above unused, so the ignored-write case is reachable. The bench drives a long back-to-back random stream to cover R2. It exercises the same-edge mask update and a total that exactly equals a threshold.

// File: rtl/gsum_pkg.sv
package gsum_pkg;

  typedef enum logic [1:0] {
    CFG_NONE = 2'd0,
    CFG_THR  = 2'd1,
    CFG_MASK = 2'd2
  } cfg_kind_e;

  // Lane contribution after the enable gate.
  function automatic logic [31:0] lane_gate(logic [31:0] v, logic en);
    return en ? v : 32'd0;
  endfunction

  // Trigger compare: at or above the threshold fires.
  function automatic logic at_or_above(logic [31:0] total, logic [31:0] thr);
    return total >= thr;
  endfunction

  // Largest total the tree can carry for a lane count and lane width.
  function automatic int unsigned peak_total(int n_in, int in_w);
    return n_in * ((1 << in_w) - 1);
  endfunction

  // Address decode of the configuration port.
  function automatic cfg_kind_e decode_addr(int addr, int n_thr, int mask_base, int mask_words);
    if (addr < n_thr) return CFG_THR;
    if (addr >= mask_base && addr < mask_base + mask_words) return CFG_MASK;
    return CFG_NONE;
  endfunction

endpackage

// File: rtl/gsum_cfg.sv
module gsum_cfg #(
  parameter int N_IN   = 160,
  parameter int SUM_W  = 16,
  parameter int N_THR  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [N_IN-1:0]         lane_en,
  output logic [N_THR*SUM_W-1:0]  thr_flat
);
  import gsum_pkg::*;

  localparam int MASK_BASE  = 1 << $clog2(N_THR + 1);
  localparam int MASK_WORDS = (N_IN + DATA_W - 1) / DATA_W;

  cfg_kind_e kind;
  int        word_idx;

  always_comb begin
    kind     = decode_addr(int'(wr_addr), N_THR, MASK_BASE, MASK_WORDS);
    word_idx = int'(wr_addr) - MASK_BASE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_en  <= '1;
      thr_flat <= '1;
    end else if (wr_en) begin
      for (int k = 0; k < N_THR; k++) begin
        if (kind == CFG_THR && int'(wr_addr) == k)
          thr_flat[k*SUM_W +: SUM_W] <= SUM_W'(wr_data);
      end
      for (int i = 0; i < N_IN; i++) begin
        if (kind == CFG_MASK && word_idx == i / DATA_W)
          lane_en[i] <= wr_data[i % DATA_W];
      end
    end
  end

endmodule

// File: rtl/gsum_tree.sv
module gsum_tree #(
  parameter int N_IN   = 160,
  parameter int IN_W   = 7,
  parameter int LEVELS = 3,
  localparam int STAGES = 3 * LEVELS,
  localparam int LANES  = 1 << STAGES,
  localparam int SUM_W  = IN_W + STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [N_IN*IN_W-1:0] in_data,
  input  logic [N_IN-1:0]      lane_en,
  output logic                 sum_valid,
  output logic [SUM_W-1:0]     sum_total
);
  import gsum_pkg::*;

  for (genvar s = 0; s <= STAGES; s++) begin : g_st
    localparam int W   = IN_W + s;
    localparam int CNT = LANES >> s;
    logic [CNT*W-1:0] nodes;
    logic             vld;

    if (s == 0) begin : g_leaf
      always_comb begin
        nodes = '0;
        for (int i = 0; i < N_IN; i++)
          nodes[i*W +: W] = W'(lane_gate(32'(in_data[i*IN_W +: IN_W]), lane_en[i]));
      end
      assign vld = in_valid;
    end else begin : g_add
      localparam int PW = W - 1;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          nodes <= '0;
          vld   <= 1'b0;
        end else begin
          vld <= g_st[s-1].vld;
          for (int i = 0; i < CNT; i++)
            nodes[i*W +: W] <= W'(g_st[s-1].nodes[2*i*PW +: PW])
                             + W'(g_st[s-1].nodes[(2*i+1)*PW +: PW]);
        end
      end
    end
  end

  assign sum_total = g_st[STAGES].nodes;
  assign sum_valid = g_st[STAGES].vld;

endmodule

// File: rtl/gsum_thresh.sv
module gsum_thresh #(
  parameter int SUM_W = 16,
  parameter int N_THR = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sum_valid,
  input  logic [SUM_W-1:0]       sum_total,
  input  logic [N_THR*SUM_W-1:0] thr_flat,
  output logic                   out_valid,
  output logic [SUM_W-1:0]       out_total,
  output logic [N_THR-1:0]       out_trig
);
  import gsum_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_total <= '0;
      out_trig  <= '0;
    end else begin
      out_valid <= sum_valid;
      if (sum_valid) begin
        out_total <= sum_total;
        for (int k = 0; k < N_THR; k++)
          out_trig[k] <= at_or_above(32'(sum_total), 32'(thr_flat[k*SUM_W +: SUM_W]));
      end
    end
  end

endmodule

// File: rtl/global_sum_trigger.sv
module global_sum_trigger #(
  parameter int N_IN   = 160,
  parameter int IN_W   = 7,
  parameter int LEVELS = 3,
  parameter int N_THR  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int SUM_W = IN_W + 3 * LEVELS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [N_IN*IN_W-1:0] in_data,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 out_valid,
  output logic [SUM_W-1:0]     out_total,
  output logic [N_THR-1:0]     out_trig
);

  // Named internal events, also observed by the bound checker.
  logic [N_IN-1:0]        lane_en;
  logic [N_THR*SUM_W-1:0] thr_flat;
  logic                   sum_valid;
  logic [SUM_W-1:0]       sum_total;

  gsum_cfg #(
    .N_IN(N_IN), .SUM_W(SUM_W), .N_THR(N_THR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lane_en(lane_en), .thr_flat(thr_flat)
  );

  gsum_tree #(
    .N_IN(N_IN), .IN_W(IN_W), .LEVELS(LEVELS)
  ) u_tree (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .lane_en(lane_en), .sum_valid(sum_valid), .sum_total(sum_total)
  );

  gsum_thresh #(
    .SUM_W(SUM_W), .N_THR(N_THR)
  ) u_thresh (
    .clk(clk), .rst_n(rst_n), .sum_valid(sum_valid), .sum_total(sum_total),
    .thr_flat(thr_flat), .out_valid(out_valid), .out_total(out_total), .out_trig(out_trig)
  );

endmodule

// File: rtl/gsum_chk.sv
module gsum_chk #(
  parameter int N_IN   = 160,
  parameter int IN_W   = 7,
  parameter int LEVELS = 3,
  parameter int N_THR  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int SUM_W  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic [N_IN-1:0]        lane_en,
  input logic [N_THR*SUM_W-1:0] thr_flat,
  input logic                   sum_valid,
  input logic [SUM_W-1:0]       sum_total,
  input logic                   out_valid,
  input logic [SUM_W-1:0]       out_total,
  input logic [N_THR-1:0]       out_trig
);
  import gsum_pkg::*;

  localparam int LAT       = 3 * LEVELS + 1;
  localparam int MASK_BASE = 1 << $clog2(N_THR + 1);
  localparam logic [SUM_W-1:0] PEAK = SUM_W'(peak_total(N_IN, IN_W));

  logic [LAT-1:0] vhist;
  always_ff @(posedge clk) begin
    if (!rst_n) vhist <= '0;
    else        vhist <= {vhist[LAT-2:0], in_valid};
  end

  // R5: output valid appears exactly LAT edges after acceptance
  p_valid_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vhist[LAT-1]);

  // R5: outputs hold while no result is presented
  p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_total) && $stable(out_trig)));

  // R3: the total never exceeds the representable peak
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_total <= PEAK);

  p_root_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> sum_total <= PEAK);

  // R4: a write to mask word 0 lands in lane 0 on the next edge
  p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == MASK_BASE) |=> lane_en[0] == $past(wr_data[0]));

  for (genvar k = 0; k < N_THR; k++) begin : g_thr
    // R6: each trigger bit matches the threshold in force when it was registered
    p_trig_compare_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_trig[k] == (out_total >= $past(thr_flat[k*SUM_W +: SUM_W])));

    // R8: a threshold write is in force from the next edge
    p_thr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) == k) |=> thr_flat[k*SUM_W +: SUM_W] == $past(wr_data[SUM_W-1:0]));
  end

endmodule

bind global_sum_trigger gsum_chk #(
  .N_IN(N_IN), .IN_W(IN_W), .LEVELS(LEVELS), .N_THR(N_THR),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .lane_en(lane_en), .thr_flat(thr_flat), .sum_valid(sum_valid),
  .sum_total(sum_total), .out_valid(out_valid), .out_total(out_total), .out_trig(out_trig)
);

// File: tb/tb_global_sum_trigger.sv
module tb_global_sum_trigger;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN   = 160;
  localparam int IN_W   = 7;
  localparam int N_THR  = 3;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int SUM_W  = 16;
  localparam int LAT    = 10;
  localparam int MW     = 10;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [N_IN*IN_W-1:0] in_data = '0;
  logic                 wr_en = 1'b0;
  logic [ADDR_W-1:0]    wr_addr = '0;
  logic [DATA_W-1:0]    wr_data = '0;
  logic                 out_valid;
  logic [SUM_W-1:0]     out_total;
  logic [N_THR-1:0]     out_trig;

  global_sum_trigger dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_total(out_total), .out_trig(out_trig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // Bench model state
  bit        mask_m [N_IN];
  int        thr_m  [N_THR];
  int        lane_v [N_IN];

  // Next-tick stimulus
  bit        drv_valid = 0;
  bit        drv_wr = 0;
  int        drv_addr = 0;
  int        drv_data = 0;
  string     drv_tag = "R1";

  // Expected results by cycle slot
  bit        exp_v   [16];
  int        exp_tot [16];
  int        exp_trg [16];
  string     exp_tag [16];
  int        last_tot = 0;
  int        last_trg = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int model_sum();
    int s = 0;
    for (int i = 0; i < N_IN; i++) if (mask_m[i]) s += lane_v[i];
    return s;
  endfunction

  function automatic int model_trig(int tot);
    int t = 0;
    for (int k = 0; k < N_THR; k++) if (tot >= thr_m[k]) t |= (1 << k);
    return t;
  endfunction

  task automatic model_write(int addr, int data);
    if (addr < N_THR) thr_m[addr] = data & 16'hFFFF;
    else if (addr >= 4 && addr < 4 + MW) begin
      for (int j = 0; j < 16; j++)
        if ((addr - 4) * 16 + j < N_IN) mask_m[(addr - 4) * 16 + j] = data[j];
    end
  endtask

  task automatic tick();
    int rs;
    int ds;
    @(negedge clk);
    cyc++;
    rs = (cyc + 16 - LAT) % 16;
    chk(out_valid == exp_v[rs], "R5 valid", int'(out_valid), int'(exp_v[rs]));
    if (exp_v[rs]) begin
      chk(int'(out_total) == exp_tot[rs], exp_tag[rs], int'(out_total), exp_tot[rs]);
      chk(int'(out_trig) == exp_trg[rs], "R6 trig", int'(out_trig), exp_trg[rs]);
      last_tot = exp_tot[rs];
      last_trg = exp_trg[rs];
    end else begin
      chk(int'(out_total) == last_tot, "R5 hold total", int'(out_total), last_tot);
      chk(int'(out_trig) == last_trg, "R5 hold trig", int'(out_trig), last_trg);
    end
    exp_v[rs] = 1'b0;
    // Drive the next edge
    in_valid = drv_valid;
    for (int i = 0; i < N_IN; i++) in_data[i*IN_W +: IN_W] = IN_W'(lane_v[i]);
    wr_en   = drv_wr;
    wr_addr = ADDR_W'(drv_addr);
    wr_data = DATA_W'(drv_data);
    ds = cyc % 16;
    exp_v[ds]   = drv_valid && rst_n;
    exp_tot[ds] = model_sum();
    exp_trg[ds] = model_trig(exp_tot[ds]);
    exp_tag[ds] = drv_tag;
    if (drv_wr && rst_n) model_write(drv_addr, drv_data);
    drv_valid = 0;
    drv_wr = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < LAT + 2; i++) tick();
  endtask

  task automatic cfg_write(int addr, int data);
    drv_wr = 1; drv_addr = addr; drv_data = data;
    tick();
  endtask

  task automatic fill(int v);
    for (int i = 0; i < N_IN; i++) lane_v[i] = v;
  endtask

  task automatic send(string tag);
    drv_valid = 1; drv_tag = tag;
    tick();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    int rnd;
    rnd = $urandom(32'h5EED_0042);
    for (int i = 0; i < N_IN; i++) begin mask_m[i] = 1; lane_v[i] = 0; end
    for (int k = 0; k < N_THR; k++) thr_m[k] = 16'hFFFF;
    for (int i = 0; i < 16; i++) begin exp_v[i] = 0; exp_tot[i] = 0; exp_trg[i] = 0; exp_tag[i] = "R1"; end

    // R9: reset state
    for (int i = 0; i < 4; i++) tick();
    chk(out_valid == 1'b0, "R9 valid", int'(out_valid), 0);
    chk(out_total == '0, "R9 total", int'(out_total), 0);
    chk(out_trig == '0, "R9 trig", int'(out_trig), 0);
    rst_n = 1'b1;
    tick();
    chk(out_total == '0 && out_trig == '0, "R9 after release", int'(out_total), 0);

    // R1: directed sums
    fill(0); send("R1 zero");
    fill(1); send("R1 ones");
    fill(0); lane_v[N_IN-1] = 127; send("R1 last lane");
    fill(0); lane_v[0] = 5; lane_v[77] = 64; send("R1 sparse");
    // R3: peak total 20320
    fill(127); send("R3 peak");
    drain();

    // R6 thresholds for the random run
    cfg_write(0, 6000);
    cfg_write(1, 10000);
    cfg_write(2, 14000);
    drain();

    // R2: back-to-back random stream
    for (int n = 0; n < 300; n++) begin
      int base;
      base = $urandom_range(0, 3);
      for (int i = 0; i < N_IN; i++)
        lane_v[i] = (base == 0) ? $urandom_range(0, 127) : $urandom_range(base * 20, base * 20 + 60);
      send("R2 stream");
    end
    drain();

    // R7: mask write on the same edge as a vector leaves that vector alone
    fill(1); lane_v[0] = 100;
    drv_wr = 1; drv_addr = 4; drv_data = 16'hFFFE;
    send("R7 same edge");
    send("R4 lane0 masked");
    // R4: last lane masked via word 9 bit 15
    cfg_write(13, 16'h7FFF);
    fill(0); lane_v[N_IN-1] = 127; lane_v[N_IN-2] = 3; send("R4 lane159 masked");
    // R4: all lanes off
    for (int w = 0; w < MW; w++) cfg_write(4 + w, 0);
    fill(127); send("R4 all masked");
    for (int w = 0; w < MW; w++) cfg_write(4 + w, 16'hFFFF);
    fill(127); send("R4 restored");
    drain();

    // R6/R8: threshold boundary, total 500
    cfg_write(0, 500);
    cfg_write(1, 501);
    cfg_write(2, 0);
    drain();
    fill(0); lane_v[0] = 127; lane_v[1] = 127; lane_v[2] = 127; lane_v[3] = 119;
    send("R8 thr equal");
    lane_v[3] = 118; send("R6 thr below");
    drain();

    // R10: writes to unused addresses change nothing
    cfg_write(3, 0);
    cfg_write(14, 0);
    cfg_write(31, 0);
    drain();
    lane_v[3] = 119; send("R10 unused addr");
    lane_v[3] = 118; send("R10 unused addr");
    drain();

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: got hung expected completion");
    summary();
    $finish;
  end

endmodule